// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps instruction completion in program order for an out-of-order core. Instructions enter through an allocate port in program order. Each one brings a destination register number and a flag that says whether it was fetched past an unresolved branch. The buffer returns the slot identifier it assigned. Execution units then report, by slot identifier, when an entry starts executing, when it finishes, and whether it faulted. The buffer tracks entries as issued, executing or finished. It hands finished entries to a retire port, oldest first and up to two per cycle. Only that port may update the architectural registers or memory.

A branch resolve port ends a speculative window. On a correct guess, the speculative entries become ordinary entries and retire in order. On a wrong guess they are cancelled, and their slots are reclaimed by moving the allocate pointer back. A fault is acted on only once the faulting entry is the oldest live, non-speculative entry. At that point the buffer raises an exception output that carries the slot identifier and flushes every entry on the next edge.

Top module: `spec_rob`

## Requirements
- R1: Allocations receive consecutive slot identifiers modulo DEPTH, and `alloc_id` always shows the slot the next allocation will take. `alloc_ready` is low once DEPTH entries are live, and an allocation request while not ready is ignored.
- R2: `stat_state` encodes 1 as executing and 2 as finished, and a new entry starts as issued. An entry that is issued or executing never retires. A status update aimed at a slot that holds no live entry has no effect.
- R3: An entry retires only when it is finished and every older entry has retired. A finished entry behind an unfinished older one waits.
- R4: At most two entries retire per cycle. The second retire slot is used only when the first is used in the same cycle, and it carries the next consecutive identifier.
- R5: An entry allocated with `alloc_spec` = 1 does not retire while its branch is unresolved, even when it is finished. Everything younger waits behind it.
- R6: `br_valid` with `br_correct` = 1 clears every speculative flag, and those entries then retire in order once finished.
- R7: `br_valid` with `br_correct` = 0 cancels every speculative entry. Cancelled entries never appear on a retire port, and the next allocation reuses the slot just after the youngest non-speculative entry.
- R8: `exc_valid` is high, with `exc_id` giving the slot, only while the oldest live entry has a recorded fault and is not speculative. A fault on a younger entry waits. While `exc_valid` is high nothing retires.
- R9: One edge after `exc_valid`, the buffer is empty and the next allocation takes slot `exc_id`.
- R10: After reset the buffer is empty: `alloc_ready` = 1, `alloc_id` = 0, and no retire or exception is signalled.
- R11: Each retire port presents the destination register number that was given when its entry was allocated.
- R12: No allocation is accepted in a cycle with `br_valid` high or `exc_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request to allocate one entry |
| alloc_dest | input | DW | Destination register number of the new entry |
| alloc_spec | input | 1 | New entry lies past an unresolved branch |
| alloc_ready | output | 1 | Allocation is accepted this cycle |
| alloc_id | output | IW | Slot that the next allocation takes |
| stat_valid | input | 1 | Status update strobe |
| stat_id | input | IW | Slot the status update targets |
| stat_state | input | 2 | New status: 1 executing, 2 finished |
| stat_exc | input | 1 | The targeted instruction faulted |
| br_valid | input | 1 | Branch outcome strobe |
| br_correct | input | 1 | 1 confirms the guess, 0 cancels speculative entries |
| ret0_valid | output | 1 | Oldest entry retires this cycle |
| ret0_id | output | IW | Slot of the oldest retiring entry |
| ret0_dest | output | DW | Destination of the oldest retiring entry |
| ret1_valid | output | 1 | Second entry retires this cycle |
| ret1_id | output | IW | Slot of the second retiring entry |
| ret1_dest | output | DW | Destination of the second retiring entry |
| exc_valid | output | 1 | Fault accepted at the oldest entry; flush on this edge |
| exc_id | output | IW | Slot of the faulting entry |

## Verification
The assertions assume that speculative entries always form one contiguous run at the young end of the buffer. In other words, once a speculative entry is allocated, no ordinary entry follows it until the branch resolves, and only one branch is outstanding at a time. They also assume that `stat_state` only carries 1 or 2. The stimulus keeps to this with a speculative-mode flag: every allocation made while the flag is set is marked speculative, a resolve clears the flag, and status values are drawn only from {1, 2}. Status identifiers are still drawn from every slot, so updates that hit dead slots are exercised as well.

// File: rtl/spec_rob_pkg.sv
`timescale 1ns/1ps
package spec_rob_pkg;

  // Progress of one entry; ST_RSVD is never written by a legal producer.
  typedef enum logic [1:0] {
    ST_ISSUED = 2'd0,
    ST_EXEC   = 2'd1,
    ST_DONE   = 2'd2,
    ST_RSVD   = 2'd3
  } rob_state_e;

endpackage

// File: rtl/rob_ptr_ctrl.sv
`timescale 1ns/1ps
// Allocate and retire pointers with a wrap bit above the slot index.
module rob_ptr_ctrl #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_alloc,
  input  logic [1:0]    ret_cnt,
  input  logic          do_cancel,
  input  logic [IW:0]   cancel_cnt,
  input  logic          do_flush,
  output logic [IW:0]   wr_ptr,
  output logic [IW:0]   rd_ptr,
  output logic [IW:0]   occ,
  output logic          full
);
  localparam int PW = IW + 1;

  function automatic logic [PW-1:0] fn_distance(input logic [PW-1:0] a,
                                                input logic [PW-1:0] b);
    return a - b;
  endfunction

  function automatic logic fn_is_full(input logic [PW-1:0] a,
                                      input logic [PW-1:0] b);
    return (a[IW] != b[IW]) && (a[IW-1:0] == b[IW-1:0]);
  endfunction

  logic [PW-1:0] wr_nxt, rd_nxt;

  always_comb begin
    rd_nxt = rd_ptr + PW'(ret_cnt);
    if (do_flush)       wr_nxt = rd_ptr;
    else if (do_cancel) wr_nxt = wr_ptr - cancel_cnt;
    else if (do_alloc)  wr_nxt = wr_ptr + PW'(1);
    else                wr_nxt = wr_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      wr_ptr <= wr_nxt;
      rd_ptr <= rd_nxt;
    end
  end

  assign occ  = fn_distance(wr_ptr, rd_ptr);
  assign full = fn_is_full(wr_ptr, rd_ptr);

endmodule

// File: rtl/rob_retire_sel.sv
`timescale 1ns/1ps
// Picks up to two in-order retirements and decides whether a fault is taken.
module rob_retire_sel
  import spec_rob_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic [(1<<IW)-1:0]      valid_i,
  input  logic [(1<<IW)-1:0]      spec_i,
  input  logic [(1<<IW)-1:0]      exc_i,
  input  logic [(1<<IW)-1:0][1:0] state_i,
  input  logic [IW-1:0]           head_i,
  output logic [IW-1:0]           idx0,
  output logic [IW-1:0]           idx1,
  output logic                    ret0_ok,
  output logic                    ret1_ok,
  output logic [1:0]              ret_cnt,
  output logic                    exc_take,
  output logic                    head_spec
);

  function automatic logic fn_can_leave(input logic v, input logic s,
                                        input logic e, input logic [1:0] st);
    return v && !s && !e && (st == ST_DONE);
  endfunction

  assign idx0 = head_i;
  assign idx1 = head_i + IW'(1);

  assign ret0_ok  = fn_can_leave(valid_i[idx0], spec_i[idx0], exc_i[idx0], state_i[idx0]);
  assign ret1_ok  = ret0_ok &&
                    fn_can_leave(valid_i[idx1], spec_i[idx1], exc_i[idx1], state_i[idx1]);
  assign ret_cnt  = 2'(ret0_ok) + 2'(ret1_ok);
  assign exc_take = valid_i[idx0] && exc_i[idx0] && !spec_i[idx0];
  assign head_spec = valid_i[idx0] && spec_i[idx0];

endmodule

// File: rtl/spec_rob.sv
`timescale 1ns/1ps
module spec_rob
  import spec_rob_pkg::*;
#(
  parameter int IW = 3,
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic [DW-1:0] alloc_dest,
  input  logic          alloc_spec,
  output logic          alloc_ready,
  output logic [IW-1:0] alloc_id,
  input  logic          stat_valid,
  input  logic [IW-1:0] stat_id,
  input  logic [1:0]    stat_state,
  input  logic          stat_exc,
  input  logic          br_valid,
  input  logic          br_correct,
  output logic          ret0_valid,
  output logic [IW-1:0] ret0_id,
  output logic [DW-1:0] ret0_dest,
  output logic          ret1_valid,
  output logic [IW-1:0] ret1_id,
  output logic [DW-1:0] ret1_dest,
  output logic          exc_valid,
  output logic [IW-1:0] exc_id
);
  localparam int DEPTH = 1 << IW;
  localparam int PW    = IW + 1;

  // Entry storage
  logic [DEPTH-1:0]         valid_q, spec_q, exc_q;
  logic [DEPTH-1:0][1:0]    state_q;
  logic [DEPTH-1:0][DW-1:0] dest_q;

  // Named internal events
  logic [PW-1:0] wr_ptr_w, rd_ptr_w, occ_w, cancel_cnt_w;
  logic          full_w, fire_alloc, fire_confirm, fire_cancel, fire_flush;
  logic          ret0_ok, ret1_ok, head_spec_w;
  logic [IW-1:0] idx0, idx1;
  logic [1:0]    ret_cnt_w;
  logic [DEPTH-1:0] alloc_hit, ret_hit, stat_hit;

  function automatic logic [PW-1:0] fn_live_spec(input logic [DEPTH-1:0] v,
                                                 input logic [DEPTH-1:0] s);
    logic [PW-1:0] n;
    n = '0;
    for (int k = 0; k < DEPTH; k++) n = n + PW'(v[k] & s[k]);
    return n;
  endfunction

  rob_retire_sel #(.IW(IW)) sel_i (
    .valid_i  (valid_q),
    .spec_i   (spec_q),
    .exc_i    (exc_q),
    .state_i  (state_q),
    .head_i   (rd_ptr_w[IW-1:0]),
    .idx0     (idx0),
    .idx1     (idx1),
    .ret0_ok  (ret0_ok),
    .ret1_ok  (ret1_ok),
    .ret_cnt  (ret_cnt_w),
    .exc_take (fire_flush),
    .head_spec(head_spec_w)
  );

  assign alloc_ready  = !full_w && !br_valid && !fire_flush;
  assign fire_alloc   = alloc_valid && alloc_ready;
  assign fire_confirm = br_valid && br_correct && !fire_flush;
  assign fire_cancel  = br_valid && !br_correct && !fire_flush;
  assign cancel_cnt_w = fn_live_spec(valid_q, spec_q);

  rob_ptr_ctrl #(.IW(IW)) ptr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_alloc  (fire_alloc),
    .ret_cnt   (ret_cnt_w),
    .do_cancel (fire_cancel),
    .cancel_cnt(cancel_cnt_w),
    .do_flush  (fire_flush),
    .wr_ptr    (wr_ptr_w),
    .rd_ptr    (rd_ptr_w),
    .occ       (occ_w),
    .full      (full_w)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign alloc_hit[g] = fire_alloc && (wr_ptr_w[IW-1:0] == IW'(g));
    assign ret_hit[g]   = (ret0_ok && (idx0 == IW'(g))) || (ret1_ok && (idx1 == IW'(g)));
    assign stat_hit[g]  = stat_valid && (stat_id == IW'(g)) && valid_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      spec_q  <= '0;
      exc_q   <= '0;
      state_q <= '0;
      dest_q  <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (fire_flush) begin
          valid_q[e] <= 1'b0;
          spec_q[e]  <= 1'b0;
          exc_q[e]   <= 1'b0;
        end else if (alloc_hit[e]) begin
          valid_q[e] <= 1'b1;
          spec_q[e]  <= alloc_spec;
          exc_q[e]   <= 1'b0;
          state_q[e] <= ST_ISSUED;
          dest_q[e]  <= alloc_dest;
        end else begin
          if (stat_hit[e]) begin
            state_q[e] <= stat_state;
            if (stat_exc) exc_q[e] <= 1'b1;
          end
          if (ret_hit[e] || (fire_cancel && spec_q[e])) begin
            valid_q[e] <= 1'b0;
            spec_q[e]  <= 1'b0;
            exc_q[e]   <= 1'b0;
          end else if (fire_confirm) begin
            spec_q[e] <= 1'b0;
          end
        end
      end
    end
  end

  assign alloc_id   = wr_ptr_w[IW-1:0];
  assign ret0_valid = ret0_ok;
  assign ret0_id    = idx0;
  assign ret0_dest  = dest_q[idx0];
  assign ret1_valid = ret1_ok;
  assign ret1_id    = idx1;
  assign ret1_dest  = dest_q[idx1];
  assign exc_valid  = fire_flush;
  assign exc_id     = idx0;

endmodule

// File: rtl/spec_rob_chk.sv
`timescale 1ns/1ps
module spec_rob_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_ready,
  input logic          full,
  input logic [IW:0]   occ,
  input logic          ret0_valid,
  input logic          ret1_valid,
  input logic [IW-1:0] ret0_id,
  input logic [IW-1:0] ret1_id,
  input logic          exc_valid,
  input logic          br_valid,
  input logic          head_spec
);
  localparam int DEPTH = 1 << IW;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (IW+1)'(DEPTH)); // R1
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_ready); // R1
  AST_PAIR_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ret1_valid |-> (ret0_valid && (ret1_id == IW'(ret0_id + 1'b1)))); // R4
  AST_SPEC_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    head_spec |-> !ret0_valid); // R5
  AST_EXC_STOPS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !ret0_valid); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (occ == '0)); // R9
  AST_RESOLVE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> (occ <= $past(occ))); // R12

endmodule

bind spec_rob spec_rob_chk #(.IW(IW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .alloc_ready(alloc_ready),
  .full       (full_w),
  .occ        (occ_w),
  .ret0_valid (ret0_valid),
  .ret1_valid (ret1_valid),
  .ret0_id    (ret0_id),
  .ret1_id    (ret1_id),
  .exc_valid  (exc_valid),
  .br_valid   (br_valid),
  .head_spec  (head_spec_w)
);

// File: tb/spec_rob_tb_top.sv
`timescale 1ns/1ps
module spec_rob_tb_top;
  localparam int IW = 3;
  localparam int DW = 5;
  localparam int D  = 1 << IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0, alloc_spec = 1'b0, stat_valid = 1'b0, stat_exc = 1'b0;
  logic br_valid = 1'b0, br_correct = 1'b0;
  logic [DW-1:0] alloc_dest = '0;
  logic [IW-1:0] stat_id = '0;
  logic [1:0]    stat_state = 2'd0;
  logic          alloc_ready, ret0_valid, ret1_valid, exc_valid;
  logic [IW-1:0] alloc_id, ret0_id, ret1_id, exc_id;
  logic [DW-1:0] ret0_dest, ret1_dest;

  always #10 clk = ~clk;

  spec_rob #(.IW(IW), .DW(DW)) dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state: oldest entry at index 0
  int q_dest[$];
  int q_st[$];
  bit q_spec[$];
  bit q_exc[$];
  int head_id = 0;
  int wr_id = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Drive at a negedge, compare before the posedge, update the reference, wait for next negedge.
  task automatic step(bit av, int ad, bit as, bit sv, int sid, int sst, bit se, bit bv, bit bc);
    int sz, n, i;
    bit e_exc, e_ready, e_r0, e_r1;
    alloc_valid = av; alloc_dest = DW'(ad); alloc_spec = as;
    stat_valid = sv; stat_id = IW'(sid); stat_state = 2'(sst); stat_exc = se;
    br_valid = bv; br_correct = bc;
    #2;
    sz = q_dest.size();
    e_exc   = (sz > 0) && q_exc[0] && !q_spec[0];
    e_ready = (sz < D) && !bv && !e_exc;
    e_r0    = (sz > 0) && (q_st[0] == 2) && !q_spec[0] && !q_exc[0];
    e_r1    = e_r0 && (sz > 1) && (q_st[1] == 2) && !q_spec[1] && !q_exc[1];
    check("R1 alloc_ready", int'(alloc_ready), int'(e_ready));
    check("R1 alloc_id", int'(alloc_id), wr_id);
    check("R3 ret0_valid", int'(ret0_valid), int'(e_r0));
    if (e_r0) begin
      check("R3 ret0_id", int'(ret0_id), head_id);
      check("R11 ret0_dest", int'(ret0_dest), q_dest[0]);
    end
    check("R4 ret1_valid", int'(ret1_valid), int'(e_r1));
    if (e_r1) begin
      check("R4 ret1_id", int'(ret1_id), (head_id + 1) % D);
      check("R11 ret1_dest", int'(ret1_dest), q_dest[1]);
    end
    check("R8 exc_valid", int'(exc_valid), int'(e_exc));
    if (e_exc) check("R8 exc_id", int'(exc_id), head_id);
    if (e_exc) begin
      q_dest.delete(); q_st.delete(); q_spec.delete(); q_exc.delete();
      wr_id = head_id;
    end else begin
      if (sv) begin
        i = (sid - head_id + D) % D;
        if (i < sz) begin
          q_st[i] = sst;
          if (se) q_exc[i] = 1'b1;
        end
      end
      n = int'(e_r0) + int'(e_r1);
      for (int k = 0; k < n; k++) begin
        void'(q_dest.pop_front()); void'(q_st.pop_front());
        void'(q_spec.pop_front()); void'(q_exc.pop_front());
      end
      head_id = (head_id + n) % D;
      if (bv) begin
        if (bc) begin
          foreach (q_spec[k]) q_spec[k] = 1'b0;
        end else begin
          while (q_spec.size() > 0 && q_spec[q_spec.size()-1]) begin
            void'(q_dest.pop_back()); void'(q_st.pop_back());
            void'(q_spec.pop_back()); void'(q_exc.pop_back());
            wr_id = (wr_id - 1 + D) % D;
          end
        end
      end
      if (av && e_ready) begin
        q_dest.push_back(ad % (1 << DW)); q_st.push_back(0);
        q_spec.push_back(as); q_exc.push_back(1'b0);
        wr_id = (wr_id + 1) % D;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle_in();
    alloc_valid = 0; stat_valid = 0; stat_exc = 0; br_valid = 0;
    #2;
  endtask

  task automatic alloc(int ad, bit as);
    step(1, ad, as, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic stat(int sid, int sst, bit se);
    step(0, 0, 0, 1, sid, sst, se, 0, 0);
  endtask

  task automatic nop();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finish_run();
  end

  initial begin
    int a_id, f_id, tmp;
    bit mode;
    bit av, as, sv, se, bv, bc;
    int sid, sst;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_in();
    // R10: reset state
    check("R10 alloc_ready after reset", int'(alloc_ready), 1);
    check("R10 alloc_id after reset", int'(alloc_id), 0);
    check("R10 no retire after reset", int'(ret0_valid), 0);
    check("R10 no exception after reset", int'(exc_valid), 0);

    // R1: fill the buffer, then a refused request
    for (int k = 0; k < D; k++) alloc(10 + k, 0);
    idle_in();
    check("R1 full refuses allocation", int'(alloc_ready), 0);
    alloc(31, 0);
    idle_in();
    check("R1 refused request leaves alloc_id", int'(alloc_id), 0);

    // R3: young entry finished first must wait
    stat(2, 2, 0);
    idle_in();
    check("R3 young finished entry waits", int'(ret0_valid), 0);
    // R2: executing state does not retire
    stat(0, 1, 0);
    idle_in();
    check("R2 executing entry does not retire", int'(ret0_valid), 0);
    stat(0, 2, 0);
    idle_in();
    check("R3 head retires once finished", int'(ret0_valid), 1);
    check("R11 head destination", int'(ret0_dest), 10);
    check("R4 second slot stays idle when next unfinished", int'(ret1_valid), 0);
    nop();
    stat(1, 2, 0);
    idle_in();
    check("R4 two entries retire together", int'(ret1_valid), 1);
    check("R4 second slot identifier", int'(ret1_id), 2);
    check("R11 second slot destination", int'(ret1_dest), 12);
    nop();
    for (int k = 3; k < D; k++) stat(k, 2, 0);
    repeat (4) nop();
    // R2: status to a dead slot is ignored
    stat(5, 2, 1);
    idle_in();
    check("R2 update to dead slot ignored", int'(exc_valid), 0);

    // R5/R7: speculation cancelled
    idle_in();
    a_id = int'(alloc_id);
    alloc(3, 0);
    alloc(4, 1);
    alloc(5, 1);
    stat(a_id, 2, 0);
    stat((a_id + 1) % D, 2, 0);
    stat((a_id + 2) % D, 2, 0);
    nop();
    idle_in();
    check("R5 finished speculative head holds", int'(ret0_valid), 0);
    alloc_valid = 1; br_valid = 1; br_correct = 0;
    #1;
    check("R12 no allocation while resolving", int'(alloc_ready), 0);
    step(1, 6, 0, 0, 0, 0, 0, 1, 0);
    idle_in();
    check("R7 allocate pointer rolls back", int'(alloc_id), (a_id + 1) % D);
    check("R7 cancelled entries never retire", int'(ret0_valid), 0);

    // R6: speculation confirmed
    tmp = int'(alloc_id);
    alloc(7, 1);
    stat(tmp, 2, 0);
    idle_in();
    check("R5 speculative entry held before resolve", int'(ret0_valid), 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1);
    idle_in();
    check("R6 confirmed entry retires", int'(ret0_valid), 1);
    check("R6 confirmed entry identifier", int'(ret0_id), tmp);
    nop();

    // R8/R9: precise exception
    idle_in();
    f_id = int'(alloc_id);
    alloc(8, 0);
    alloc(9, 0);
    stat((f_id + 1) % D, 2, 1);
    idle_in();
    check("R8 younger fault waits", int'(exc_valid), 0);
    stat(f_id, 2, 1);
    idle_in();
    check("R8 fault taken at head", int'(exc_valid), 1);
    check("R8 fault identifier", int'(exc_id), f_id);
    nop();
    idle_in();
    check("R9 flush empties buffer", int'(alloc_ready), 1);
    check("R9 next slot after flush", int'(alloc_id), f_id);
    check("R9 nothing retires after flush", int'(ret0_valid), 0);

    // Near-exhaustive random sweep under the speculation contract
    mode = 0;
    for (int n = 0; n < 6000; n++) begin
      av = ($urandom % 10) < 7;
      if (!mode && ($urandom % 12) == 0) mode = 1;
      as = mode;
      sv = ($urandom % 3) != 0;
      sid = $urandom % D;
      sst = (($urandom % 4) == 0) ? 1 : 2;
      se = ($urandom % 25) == 0;
      bv = 0; bc = 0;
      if (mode && ($urandom % 8) == 0) begin
        bv = 1; bc = $urandom % 2; mode = 0;
      end else if (!mode && ($urandom % 40) == 0) begin
        bv = 1; bc = $urandom % 2;
      end
      step(av, $urandom % 32, as, sv, sid, sst, se, bv, bc);
    end
    finish_run();
  end

endmodule